// File: doc/BRIEF.md
# Same-Address Memory Ordering Tracker

This block sits between a thread's memory-request issue port and the memory pipeline. Each request is a load, store, atomic or reduction, and each carries an address. Reductions are fire-and-forget: the tracker records each reduction it sends downstream in a small table of pending entries and returns to the issuer at once. Later on, the memory side reports completion with the entry index, and that entry is freed.

Any later request whose address matches a pending reduction is held back until that reduction completes. Requests to other addresses are free to overtake it. The tracker has a single park slot that holds one stalled request. While that request waits, later requests to unrelated addresses keep flowing past it. If the table is full, a new reduction waits in the park slot until an entry frees.

The tracker sends at most one request downstream per cycle. A request issued straight from the input leaves in the same cycle it is accepted.

Top module: `memOrderTracker`

## Requirements
- R1: After reset no entry is pending and the park slot is empty. With no request offered, `reqReady` is 1 and `issValid` is 0.
- R2: The kind encoding is 0 load, 1 store, 2 atomic, 3 reduction. A load, store or atomic whose address matches no pending reduction issues in the cycle it is accepted, with its kind and address unchanged. It allocates no entry.
- R3: A reduction that issues takes the lowest-numbered entry that is free after this cycle's completion. It reports that index on `issIdx`.
- R4: With the park slot empty, a request whose address matches a pending reduction is still accepted (`reqReady` 1). It is not issued, and it waits in the park slot.
- R5: A parked request issues in the cycle that the completion of its blocking entry arrives. Its kind and address are preserved.
- R6: While a request is parked, a request to an address that is neither pending nor parked issues directly, overtaking the parked one.
- R7: While a request is parked, `reqReady` is 0 for a request that would have to wait. That covers three cases: its address is pending, its address equals the parked address, or it is a reduction and no entry is free.
- R8: When all 8 entries are pending, a new reduction does not issue. A completion frees its entry in the same cycle, so a reduction offered in the completion cycle, or parked before it, issues with the freed index.
- R9: After a completion, a request to the freed address issues directly. This also holds for a request offered in the very cycle of that completion.
- R10: In a cycle where the parked request issues, `reqReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is offered |
| reqKind | input | 2 | 0 load, 1 store, 2 atomic, 3 reduction |
| reqAddr | input | ADDR_W | Request address |
| reqReady | output | 1 | Request taken this cycle |
| cplValid | input | 1 | A pending reduction has completed |
| cplIdx | input | IDX_W | Entry index of the completed reduction |
| issValid | output | 1 | A request goes to the memory pipeline |
| issKind | output | 2 | Kind of the issued request |
| issAddr | output | ADDR_W | Address of the issued request |
| issIdx | output | IDX_W | Entry allocated, meaningful for reductions |

## Verification
Two functions can fall in the same cycle: a completion that frees an entry, and a new decision that reads the table. The decision may be an address compare or a free-entry search. The bench provokes this in two ways. First, it offers a load to an address in the exact cycle its reduction completes, and requires a direct issue. Second, it fills the table and offers a reduction together with a completion, and requires the freed index on `issIdx`. A third case has the parked request released by a completion while a new request is offered in the same cycle. The outputs are judged in that cycle: the parked request must leave, and the new one must see `reqReady` at 0.

// File: rtl/memOrdPkg.sv
package memOrdPkg;
  typedef enum logic [1:0] {
    KIND_LOAD   = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_ATOMIC = 2'd2,
    KIND_RED    = 2'd3
  } reqKindE;

  typedef struct packed {
    logic issueIn;    // send the incoming request downstream
    logic issuePark;  // send the parked request downstream
    logic loadPark;   // capture the incoming request into the park slot
  } ordStrobesT;
endpackage

// File: rtl/memOrdDatapath.sv
module memOrdDatapath
  import memOrdPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  reqKindE           reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              cplValid,
  input  logic [IDX_W-1:0]  cplIdx,
  input  ordStrobesT        strobes,
  output logic              inHit,
  output logic              parkHit,
  output logic              inParkSame,
  output logic              anyFree,
  output logic              parkValid,
  output logic              parkIsRed,
  output logic              issValid,
  output reqKindE           issKind,
  output logic [ADDR_W-1:0] issAddr,
  output logic [IDX_W-1:0]  issIdx
);
  logic [DEPTH-1:0]  entryValid;
  logic [ADDR_W-1:0] entryAddr [DEPTH];
  logic [DEPTH-1:0]  cplMask, liveMask, inMatch, parkMatch, issMatch, allocMask;
  logic [ADDR_W-1:0] parkAddr;
  reqKindE           parkKind;
  logic [IDX_W-1:0]  freeIdx;
  logic              doAlloc;

  // Entries freed this cycle already count as free.
  always_comb begin
    cplMask = '0;
    if (cplValid) cplMask[cplIdx] = 1'b1;
    liveMask = entryValid & ~cplMask;
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
      assign inMatch[e]   = liveMask[e] && (entryAddr[e] == reqAddr);
      assign parkMatch[e] = liveMask[e] && (entryAddr[e] == parkAddr);
      assign issMatch[e]  = liveMask[e] && (entryAddr[e] == issAddr);
    end
  endgenerate

  assign inHit      = |inMatch;
  assign parkHit    = parkValid && (|parkMatch);
  assign inParkSame = parkValid && (parkAddr == reqAddr);
  assign anyFree    = ~&liveMask;
  assign parkIsRed  = parkKind == KIND_RED;

  // Lowest free index search.
  always_comb begin
    freeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!liveMask[i]) freeIdx = IDX_W'(i);
  end

  assign issValid = strobes.issueIn || strobes.issuePark;
  assign issKind  = strobes.issuePark ? parkKind : reqKind;
  assign issAddr  = strobes.issuePark ? parkAddr : reqAddr;
  assign issIdx   = freeIdx;
  assign doAlloc  = issValid && (issKind == KIND_RED);

  always_comb begin
    allocMask = '0;
    if (doAlloc) allocMask[freeIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryValid <= '0;
    end else begin
      entryValid <= liveMask | allocMask;
    end
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_addr
      always_ff @(posedge clk) begin
        if (!rstN) entryAddr[e] <= '0;
        else if (allocMask[e]) entryAddr[e] <= issAddr;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parkValid <= 1'b0;
      parkAddr  <= '0;
      parkKind  <= KIND_LOAD;
    end else if (strobes.loadPark) begin
      parkValid <= 1'b1;
      parkAddr  <= reqAddr;
      parkKind  <= reqKind;
    end else if (strobes.issuePark) begin
      parkValid <= 1'b0;
    end
  end

  // R3: the allocated entry must not still be held after completion.
  assert_alloc_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    doAlloc |-> !liveMask[freeIdx]);

  // R4: nothing issued may collide with a live pending reduction.
  assert_no_issue_conflict_R4: assert property (@(posedge clk) disable iff (!rstN)
    issValid |-> !(|issMatch));

  // R5: a parked request holds its slot until it issues.
  assert_park_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (parkValid && !strobes.issuePark) |=> (parkValid && $stable(parkAddr)));

  // R8: at most one new entry per cycle.
  assert_one_alloc_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(entryValid) <= $countones($past(entryValid)) + 1));
endmodule

// File: rtl/memOrdControl.sv
module memOrdControl
  import memOrdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  reqKindE    reqKind,
  input  logic       inHit,
  input  logic       parkHit,
  input  logic       inParkSame,
  input  logic       anyFree,
  input  logic       parkValid,
  input  logic       parkIsRed,
  output logic       reqReady,
  output ordStrobesT strobes
);
  logic parkGo, inBlocked, take;

  assign parkGo    = parkValid && !parkHit && (!parkIsRed || anyFree);
  assign inBlocked = inHit || inParkSame || ((reqKind == KIND_RED) && !anyFree);
  assign reqReady  = !parkGo && (!parkValid || !inBlocked);
  assign take      = reqValid && reqReady;

  always_comb begin
    strobes.issueIn   = take && !inBlocked;
    strobes.issuePark = parkGo;
    strobes.loadPark  = take && inBlocked;
  end

  // R10: one downstream slot, never two sources at once.
  assert_one_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.issueIn && strobes.issuePark));

  // R7: the park slot is only loaded when it is empty.
  assert_park_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPark |-> !parkValid);
endmodule

// File: rtl/memOrderTracker.sv
module memOrderTracker
  import memOrdPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  input  logic              cplValid,
  input  logic [IDX_W-1:0]  cplIdx,
  output logic              issValid,
  output logic [1:0]        issKind,
  output logic [ADDR_W-1:0] issAddr,
  output logic [IDX_W-1:0]  issIdx
);
  ordStrobesT strobes;
  reqKindE    inKind, outKind;
  logic       inHit, parkHit, inParkSame, anyFree, parkValid, parkIsRed;

  assign inKind  = reqKindE'(reqKind);
  assign issKind = outKind;

  memOrdControl u_ctrl (
    .clk, .rstN, .reqValid, .reqKind(inKind), .inHit, .parkHit, .inParkSame,
    .anyFree, .parkValid, .parkIsRed, .reqReady, .strobes
  );

  memOrdDatapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dp (
    .clk, .rstN, .reqKind(inKind), .reqAddr, .cplValid, .cplIdx, .strobes,
    .inHit, .parkHit, .inParkSame, .anyFree, .parkValid, .parkIsRed,
    .issValid, .issKind(outKind), .issAddr, .issIdx
  );

  // R4: with the park slot empty every offered request is taken.
  assert_ready_when_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    !parkValid |-> reqReady);
endmodule

// File: tb/memOrderTracker_bench.sv
module memOrderTracker_bench;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [1:0]        reqKind = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqReady;
  logic              cplValid = 1'b0;
  logic [IDX_W-1:0]  cplIdx = '0;
  logic              issValid;
  logic [1:0]        issKind;
  logic [ADDR_W-1:0] issAddr;
  logic [IDX_W-1:0]  issIdx;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  memOrderTracker u_memOrderTracker (.*);

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive at the falling edge, let logic settle, then sample.
  task automatic drive(logic v, logic [1:0] k, logic [31:0] a, logic cv, logic [2:0] ci);
    @(negedge clk);
    reqValid = v; reqKind = k; reqAddr = a; cplValid = cv; cplIdx = ci;
    #1;
  endtask

  task automatic issueExpect(string req, logic rdy, logic iv, logic [1:0] k,
                             logic [31:0] a);
    check(req, "reqReady", reqReady, rdy);
    check(req, "issValid", issValid, iv);
    if (iv) begin
      check(req, "issKind", issKind, k);
      check(req, "issAddr", issAddr, a);
    end
  endtask

  task automatic testReset();
    drive(0, 0, 0, 0, 0);
    issueExpect("R1", 1, 0, 0, 0);
  endtask

  task automatic testPlain();
    drive(1, 0, 32'h100, 0, 0); issueExpect("R2", 1, 1, 0, 32'h100);
    drive(1, 1, 32'h104, 0, 0); issueExpect("R2", 1, 1, 1, 32'h104);
    drive(1, 2, 32'h108, 0, 0); issueExpect("R2", 1, 1, 2, 32'h108);
    drive(0, 0, 0, 0, 0);       issueExpect("R2", 1, 0, 0, 0);
  endtask

  task automatic testAlloc();
    for (int k = 0; k < 3; k++) begin
      drive(1, 3, 32'h200 + 32'(4 * k), 0, 0);
      issueExpect("R3", 1, 1, 3, 32'h200 + 32'(4 * k));
      check("R3", "issIdx", issIdx, 64'(k));
    end
  endtask

  task automatic testPark();
    drive(1, 0, 32'h204, 0, 0); issueExpect("R4", 1, 0, 0, 0);
    drive(1, 1, 32'h300, 0, 0); issueExpect("R6", 1, 1, 1, 32'h300);
    drive(1, 1, 32'h204, 0, 0); issueExpect("R7", 0, 0, 0, 0);
    drive(1, 3, 32'h208, 0, 0); issueExpect("R7", 0, 0, 0, 0);
    drive(1, 1, 32'h400, 1, 1); issueExpect("R5", 0, 1, 0, 32'h204);
    check("R10", "reqReady on release", reqReady, 0);
    drive(1, 1, 32'h400, 0, 0); issueExpect("R6", 1, 1, 1, 32'h400);
  endtask

  task automatic testSameCycleFree();
    drive(1, 0, 32'h200, 1, 0); issueExpect("R9", 1, 1, 0, 32'h200);
    drive(1, 2, 32'h200, 0, 0); issueExpect("R9", 1, 1, 2, 32'h200);
    drive(1, 2, 32'h204, 0, 0); issueExpect("R9", 1, 1, 2, 32'h204);
  endtask

  task automatic testFull();
    // Entry 2 is still pending; the remaining seven get filled.
    int order [7] = '{0, 1, 3, 4, 5, 6, 7};
    for (int k = 0; k < 7; k++) begin
      drive(1, 3, 32'h500 + 32'(4 * k), 0, 0);
      issueExpect("R3", 1, 1, 3, 32'h500 + 32'(4 * k));
      check("R3", "issIdx lowest free", issIdx, 64'(order[k]));
    end
    drive(1, 3, 32'h600, 0, 0); issueExpect("R8", 1, 0, 0, 0);
    drive(1, 3, 32'h604, 0, 0); issueExpect("R7", 0, 0, 0, 0);
    drive(0, 0, 0, 1, 4);       issueExpect("R8", 0, 1, 3, 32'h600);
    check("R8", "issIdx freed", issIdx, 4);
    drive(1, 3, 32'h608, 1, 6); issueExpect("R8", 1, 1, 3, 32'h608);
    check("R8", "issIdx same cycle", issIdx, 6);
    drive(1, 0, 32'h608, 0, 0); issueExpect("R4", 1, 0, 0, 0);
    drive(0, 0, 0, 0, 0);       issueExpect("R4", 1, 0, 0, 0);
    check("R5", "still parked", issValid, 0);
    drive(0, 0, 0, 1, 6);       issueExpect("R5", 0, 1, 0, 32'h608);
    drive(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testPlain();
    testAlloc();
    testPark();
    testSameCycleFree();
    testFull();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule